// File: doc/BRIEF.md
# Instrument Status Summary and Service-Request Logic

This block gathers the status of a bus-controlled measurement instrument into one serial-poll byte and drives a service-request line toward the bus controller. It keeps two sticky event registers. One is a device-specific register whose bit 4 flags an overrange. The other is a standard event register. Each has its own enable mask. The serial-poll byte combines live conditions with one summary bit per event register. Those conditions are: ready to measure, output queue holds data, and input queue has no pending commands. A summary bit is set while any event bit whose enable bit is 1 is set.

A service request is raised only when a bit of the serial-poll byte that its enable mask lets through changes from 0 to 1. It is held until the host reads the serial-poll byte or until every enabled bit has cleared. The three enable registers each have a copy in a retained shadow. On a power-on reset, a status-clear flag selects between zeroing all enables and restoring them from the shadow. A separate cold reset wipes the shadow itself. The bus engine, parser and queues are outside the block; only their flags come in. All pins are plain control and status wires, so there is no streaming interface and no back-pressure.

Top module: `svc_status_hub`

## Requirements
- R1: The serial-poll byte `sp_byte` follows its live inputs in the same cycle. Bit 0 is `meas_ready`, bit 4 is `out_q_nonempty` and bit 7 is `in_q_empty`. Bits 1 and 2 always read 0.
- R2: `sp_byte` bit 3 is the OR of (`lcr_status` AND `lcr_en_q`). `sp_byte` bit 5 is the OR of (`std_status` AND `std_en_q`). Both follow their sources with no latching.
- R3: A 1 on a bit of `lcr_evt` or `std_evt` sets that status bit at the next clock edge. The bit then holds until it is cleared. When an event and a clear fall in the same cycle, the event wins.
- R4: `lcr_rd` clears only `lcr_status`, `std_rd` clears only `std_status`, and `cls` clears both.
- R5: `srq` goes to 1 one clock after some bit of (`sp_byte` AND `sp_en_q`, excluding bit 6) changes from 0 to 1. A bit that stays set does not raise a second request; it must clear and set again first.
- R6: Once raised, `srq` stays 1 until an `sp_rd` strobe arrives or until the enabled vector of R5 is all zero. `sp_byte` bit 6 always equals `srq`.
- R7: Bit 6 of the serial-poll enable is always stored as 0. Writing 0xFF reads back as 0xBF.
- R8: Set the device enable to 0x10 and the serial-poll enable to 0x08, then pulse `lcr_evt` bit 4. `sp_byte` bit 3 becomes 1 and `srq` rises exactly once.
- R9: While `rst_n` is low with `psc_flag` = 1, all three enables become 0. With `psc_flag` = 0 they are reloaded from the last written values, which a zeroing reset leaves untouched. `cold_rst_n` low clears both the stored values and the enables.
- R10: After reset both status registers and `srq` are 0. If a retained enable lets a live condition through, `srq` is raised one clock after reset releases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous power-on reset, active low |
| cold_rst_n | input | 1 | Synchronous cold reset that also clears the retained enables, active low |
| psc_flag | input | 1 | 1: zero the enables at power-on; 0: restore them |
| meas_ready | input | 1 | Instrument ready to measure (level) |
| out_q_nonempty | input | 1 | Output queue holds data (level) |
| in_q_empty | input | 1 | No unexecuted commands pending (level) |
| lcr_evt | input | 8 | Device event set pulses; bit 4 is overrange |
| std_evt | input | 8 | Standard event set pulses |
| lcr_en_we | input | 1 | Write strobe for the device enable |
| std_en_we | input | 1 | Write strobe for the standard event enable |
| sp_en_we | input | 1 | Write strobe for the serial-poll enable |
| wr_data | input | 8 | Data for the enable writes |
| lcr_rd | input | 1 | Read-and-clear strobe for the device status |
| std_rd | input | 1 | Read-and-clear strobe for the standard status |
| sp_rd | input | 1 | Serial-poll read; acknowledges the request |
| cls | input | 1 | Clear-status command |
| lcr_status | output | 8 | Device event status register |
| std_status | output | 8 | Standard event status register |
| sp_byte | output | 8 | Serial-poll status byte |
| lcr_en_q | output | 8 | Device enable readback |
| std_en_q | output | 8 | Standard enable readback |
| sp_en_q | output | 8 | Serial-poll enable readback |
| srq | output | 1 | Service request |

## Verification
The assertions assume that `rst_n` and `cold_rst_n` are both low at time zero. They also assume that strobes and event pulses change only between clock edges, so each one is seen at a single edge. The stickiness property counts on no clear strobe being active in the cycle it watches. The hold property counts on `sp_rd` being the only acknowledge. The bench drives every input on the falling edge, holds each strobe for exactly one cycle, and starts with both resets low. It makes enable writes only while reset is released, so the shadow update rule is exercised as intended.

// File: rtl/svc_status_pkg.sv
package svc_status_pkg;
  localparam int unsigned STAT_W = 8;
  localparam int unsigned SP_READY = 0;
  localparam int unsigned SP_LCR   = 3;
  localparam int unsigned SP_MAV   = 4;
  localparam int unsigned SP_ESB   = 5;
  localparam int unsigned SP_RQS   = 6;
  localparam int unsigned SP_NOCMD = 7;
  localparam logic [STAT_W-1:0] SP_EN_KEEP = ~(STAT_W'(1) << SP_RQS);
  localparam logic [STAT_W-1:0] ALL_KEEP   = '1;
  typedef logic [STAT_W-1:0] stat_t;
endpackage

// File: rtl/evt_latch.sv
module evt_latch #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic         clr_i,
  input  logic [W-1:0] en_i,
  output logic [W-1:0] stat_o,
  output logic         sum_o
);
  logic [W-1:0] q;

  // set wins over a same-cycle clear
  always_ff @(posedge clk) begin
    if (!rst_n)     q <= '0;
    else if (clr_i) q <= set_i;
    else            q <= q | set_i;
  end

  assign stat_o = q;
  assign sum_o  = |(q & en_i);
endmodule

// File: rtl/enable_bank.sv
module enable_bank #(
  parameter int unsigned   W         = 8,
  parameter logic [W-1:0]  KEEP_MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cold_rst_n,
  input  logic         psc_i,
  input  logic         we_i,
  input  logic [W-1:0] wd_i,
  output logic [W-1:0] en_o
);
  logic [W-1:0] shadow_q;
  logic [W-1:0] en_q;

  // retained copy, survives a power-on reset
  always_ff @(posedge clk) begin
    if (!cold_rst_n)        shadow_q <= '0;
    else if (rst_n && we_i) shadow_q <= wd_i & KEEP_MASK;
  end

  always_ff @(posedge clk) begin
    if (!cold_rst_n) en_q <= '0;
    else if (!rst_n) en_q <= psc_i ? '0 : shadow_q;
    else if (we_i)   en_q <= wd_i & KEEP_MASK;
  end

  assign en_o = en_q;
endmodule

// File: rtl/srq_gen.sv
module srq_gen
  import svc_status_pkg::*;
#(
  parameter int unsigned W = STAT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cond_i,
  input  logic [W-1:0] en_i,
  input  logic         ack_i,
  output logic         srq_o
);
  localparam logic [W-1:0] NO_RQS = ~(W'(1) << SP_RQS);

  logic [W-1:0] masked;
  logic [W-1:0] prev_q;
  logic         rqs_q;
  logic         rise;

  assign masked = cond_i & en_i & NO_RQS;
  assign rise   = |(masked & ~prev_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= '0;
      rqs_q  <= 1'b0;
    end else begin
      prev_q <= masked;
      rqs_q  <= rise | (rqs_q & ~ack_i & (|masked));
    end
  end

  assign srq_o = rqs_q;
endmodule

// File: rtl/svc_status_hub.sv
module svc_status_hub
  import svc_status_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cold_rst_n,
  input  logic        psc_flag,
  input  logic        meas_ready,
  input  logic        out_q_nonempty,
  input  logic        in_q_empty,
  input  logic [7:0]  lcr_evt,
  input  logic [7:0]  std_evt,
  input  logic        lcr_en_we,
  input  logic        std_en_we,
  input  logic        sp_en_we,
  input  logic [7:0]  wr_data,
  input  logic        lcr_rd,
  input  logic        std_rd,
  input  logic        sp_rd,
  input  logic        cls,
  output logic [7:0]  lcr_status,
  output logic [7:0]  std_status,
  output logic [7:0]  sp_byte,
  output logic [7:0]  lcr_en_q,
  output logic [7:0]  std_en_q,
  output logic [7:0]  sp_en_q,
  output logic        srq
);
  stat_t lcr_en, std_en, sp_en;
  stat_t sp_cond;
  logic  lcr_sum, esb_sum;

  enable_bank #(.W(STAT_W), .KEEP_MASK(ALL_KEEP)) u_en_lcr (
    .clk(clk), .rst_n(rst_n), .cold_rst_n(cold_rst_n), .psc_i(psc_flag),
    .we_i(lcr_en_we), .wd_i(wr_data), .en_o(lcr_en));

  enable_bank #(.W(STAT_W), .KEEP_MASK(ALL_KEEP)) u_en_std (
    .clk(clk), .rst_n(rst_n), .cold_rst_n(cold_rst_n), .psc_i(psc_flag),
    .we_i(std_en_we), .wd_i(wr_data), .en_o(std_en));

  enable_bank #(.W(STAT_W), .KEEP_MASK(SP_EN_KEEP)) u_en_sp (
    .clk(clk), .rst_n(rst_n), .cold_rst_n(cold_rst_n), .psc_i(psc_flag),
    .we_i(sp_en_we), .wd_i(wr_data), .en_o(sp_en));

  evt_latch #(.W(STAT_W)) u_lcr (
    .clk(clk), .rst_n(rst_n), .set_i(lcr_evt), .clr_i(lcr_rd | cls),
    .en_i(lcr_en), .stat_o(lcr_status), .sum_o(lcr_sum));

  evt_latch #(.W(STAT_W)) u_std (
    .clk(clk), .rst_n(rst_n), .set_i(std_evt), .clr_i(std_rd | cls),
    .en_i(std_en), .stat_o(std_status), .sum_o(esb_sum));

  // live condition vector, request bit left at 0
  always_comb begin
    sp_cond           = '0;
    sp_cond[SP_READY] = meas_ready;
    sp_cond[SP_LCR]   = lcr_sum;
    sp_cond[SP_MAV]   = out_q_nonempty;
    sp_cond[SP_ESB]   = esb_sum;
    sp_cond[SP_NOCMD] = in_q_empty;
  end

  srq_gen #(.W(STAT_W)) u_srq (
    .clk(clk), .rst_n(rst_n), .cond_i(sp_cond), .en_i(sp_en),
    .ack_i(sp_rd), .srq_o(srq));

  always_comb begin
    sp_byte         = sp_cond;
    sp_byte[SP_RQS] = srq;
  end

  assign lcr_en_q = lcr_en;
  assign std_en_q = std_en;
  assign sp_en_q  = sp_en;
endmodule

// File: rtl/svc_status_chk.sv
module svc_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       meas_ready,
  input logic       out_q_nonempty,
  input logic       in_q_empty,
  input logic       lcr_rd,
  input logic       sp_rd,
  input logic       cls,
  input logic [7:0] lcr_status,
  input logic [7:0] sp_byte,
  input logic [7:0] lcr_en_q,
  input logic [7:0] sp_en_q,
  input logic       srq
);
  logic [7:0] enabled_vec;
  assign enabled_vec = sp_byte & sp_en_q & 8'hBF;

  assert_sp_layout_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_byte[2:1] == 2'b00) && (sp_byte[0] == meas_ready) &&
    (sp_byte[4] == out_q_nonempty) && (sp_byte[7] == in_q_empty));

  assert_lcr_summary_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sp_byte[3] == |(lcr_status & lcr_en_q));

  assert_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!lcr_rd && !cls) |=> ((lcr_status & $past(lcr_status)) == $past(lcr_status)));

  assert_srq_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (srq && !sp_rd && (|enabled_vec)) |=> srq);

  assert_rqs_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sp_byte[6] == srq);

  assert_sp_en_bit6_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sp_en_q[6] == 1'b0);
endmodule

bind svc_status_hub svc_status_chk u_chk (
  .clk(clk), .rst_n(rst_n), .meas_ready(meas_ready),
  .out_q_nonempty(out_q_nonempty), .in_q_empty(in_q_empty),
  .lcr_rd(lcr_rd), .sp_rd(sp_rd), .cls(cls), .lcr_status(lcr_status),
  .sp_byte(sp_byte), .lcr_en_q(lcr_en_q), .sp_en_q(sp_en_q), .srq(srq));

// File: tb/sim_svc_status_hub.sv
`timescale 1ns/1ps
module sim_svc_status_hub;
  logic clk = 1'b0;
  logic rst_n = 1'b0, cold_rst_n = 1'b0, psc_flag = 1'b0;
  logic meas_ready = 1'b0, out_q_nonempty = 1'b0, in_q_empty = 1'b0;
  logic [7:0] lcr_evt = '0, std_evt = '0, wr_data = '0;
  logic lcr_en_we = 1'b0, std_en_we = 1'b0, sp_en_we = 1'b0;
  logic lcr_rd = 1'b0, std_rd = 1'b0, sp_rd = 1'b0, cls = 1'b0;
  logic [7:0] lcr_status, std_status, sp_byte, lcr_en_q, std_en_q, sp_en_q;
  logic srq;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  svc_status_hub u0 (
    .clk(clk), .rst_n(rst_n), .cold_rst_n(cold_rst_n), .psc_flag(psc_flag),
    .meas_ready(meas_ready), .out_q_nonempty(out_q_nonempty), .in_q_empty(in_q_empty),
    .lcr_evt(lcr_evt), .std_evt(std_evt), .lcr_en_we(lcr_en_we), .std_en_we(std_en_we),
    .sp_en_we(sp_en_we), .wr_data(wr_data), .lcr_rd(lcr_rd), .std_rd(std_rd),
    .sp_rd(sp_rd), .cls(cls), .lcr_status(lcr_status), .std_status(std_status),
    .sp_byte(sp_byte), .lcr_en_q(lcr_en_q), .std_en_q(std_en_q), .sp_en_q(sp_en_q),
    .srq(srq));

  // {meas_ready, out_q_nonempty, in_q_empty, expected sp_byte with all enables 0}
  localparam logic [10:0] VEC [8] = '{
    {3'b000, 8'h00}, {3'b001, 8'h80}, {3'b010, 8'h10}, {3'b011, 8'h90},
    {3'b100, 8'h01}, {3'b101, 8'h81}, {3'b110, 8'h11}, {3'b111, 8'h91}};

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic wr_en(input int which, input logic [7:0] d);
    wr_data = d;
    if (which == 0) lcr_en_we = 1'b1;
    else if (which == 1) std_en_we = 1'b1;
    else sp_en_we = 1'b1;
    tick();
    lcr_en_we = 1'b0; std_en_we = 1'b0; sp_en_we = 1'b0;
  endtask

  task automatic pulse_lcr(input logic [7:0] v);
    lcr_evt = v; tick(); lcr_evt = '0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got 0x00 expected 0x01");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int rises;
    logic prev;
    tick(3);
    cold_rst_n = 1'b1; rst_n = 1'b1;
    tick();
    // R10 reset state
    check("R10 lcr_status", lcr_status, 8'h00);
    check("R10 std_status", std_status, 8'h00);
    check("R10 srq", {7'd0, srq}, 8'h00);
    check("R9 cold enables", lcr_en_q | std_en_q | sp_en_q, 8'h00);

    // R1 table walk of live bits
    for (int i = 0; i < 8; i++) begin
      {meas_ready, out_q_nonempty, in_q_empty} = VEC[i][10:8];
      #1;
      check("R1 layout", sp_byte, VEC[i][7:0]);
      tick();
    end
    meas_ready = 1'b0; out_q_nonempty = 1'b0; in_q_empty = 1'b0;

    // R7 bit 6 of serial-poll enable
    wr_en(2, 8'hFF);
    check("R7 sp_en bit6", sp_en_q, 8'hBF);

    // R8 overrange example
    wr_en(2, 8'h08);
    wr_en(0, 8'h10);
    tick();
    pulse_lcr(8'h10);
    check("R8 lcr_status", lcr_status, 8'h10);
    check("R8 sp bit3", {7'd0, sp_byte[3]}, 8'h01);
    check("R5 srq lags one clock", {7'd0, srq}, 8'h00);
    rises = 0; prev = 1'b0;
    for (int k = 0; k < 10; k++) begin
      tick();
      if (srq && !prev) rises++;
      prev = srq;
    end
    check("R8 single request", rises[7:0], 8'h01);
    check("R6 srq held", {7'd0, srq}, 8'h01);
    check("R6 bit6 mirrors srq", {7'd0, sp_byte[6]}, 8'h01);

    // R6 acknowledge by serial-poll read
    sp_rd = 1'b1; tick(); sp_rd = 1'b0;
    check("R6 ack clears srq", {7'd0, srq}, 8'h00);
    check("R2 summary still set", {7'd0, sp_byte[3]}, 8'h01);
    // R5 bit already set: no new request
    pulse_lcr(8'h10);
    tick(2);
    check("R5 no re-request", {7'd0, srq}, 8'h00);
    // R4 lcr read clears; R5 re-arm
    lcr_rd = 1'b1; tick(); lcr_rd = 1'b0;
    check("R4 lcr_rd clears", lcr_status, 8'h00);
    tick();
    pulse_lcr(8'h10);
    tick();
    check("R5 re-armed request", {7'd0, srq}, 8'h01);
    // R6 condition goes away
    cls = 1'b1; tick(); cls = 1'b0;
    tick();
    check("R6 cleared by condition", {7'd0, srq}, 8'h00);

    // R3 sticky, set wins over clear; R4 selective clears
    pulse_lcr(8'h04);
    std_evt = 8'h21; tick(); std_evt = '0;
    tick(3);
    check("R3 sticky std", std_status, 8'h21);
    std_rd = 1'b1; std_evt = 8'h02; tick(); std_rd = 1'b0; std_evt = '0;
    check("R3 set wins over clear", std_status, 8'h02);
    check("R4 std_rd leaves lcr", lcr_status, 8'h04);

    // R2 standard summary bit
    wr_en(1, 8'h02); #1;
    check("R2 esb set", {7'd0, sp_byte[5]}, 8'h01);
    wr_en(1, 8'h01); #1;
    check("R2 esb masked", {7'd0, sp_byte[5]}, 8'h00);
    cls = 1'b1; tick(); cls = 1'b0;
    check("R4 cls clears both", lcr_status | std_status, 8'h00);

    // R5 level condition edge
    wr_en(2, 8'h10);
    tick(2);
    check("R5 idle before edge", {7'd0, srq}, 8'h00);
    out_q_nonempty = 1'b1; tick();
    check("R5 level edge request", {7'd0, srq}, 8'h01);
    out_q_nonempty = 1'b0; tick(2);

    // R9 retention and power-on clear
    wr_en(0, 8'h5A); wr_en(1, 8'h3C); wr_en(2, 8'h81);
    in_q_empty = 1'b1;
    psc_flag = 1'b0; rst_n = 1'b0; tick(2); rst_n = 1'b1;
    tick();
    check("R9 lcr_en restored", lcr_en_q, 8'h5A);
    check("R9 std_en restored", std_en_q, 8'h3C);
    check("R9 sp_en restored", sp_en_q, 8'h81);
    check("R10 srq on power-up", {7'd0, srq}, 8'h01);
    psc_flag = 1'b1; rst_n = 1'b0; tick(2); rst_n = 1'b1;
    tick();
    check("R9 psc zeroes", lcr_en_q | std_en_q | sp_en_q, 8'h00);
    check("R10 srq after zeroing", {7'd0, srq}, 8'h00);
    psc_flag = 1'b0; rst_n = 1'b0; tick(2); rst_n = 1'b1;
    tick();
    check("R9 shadow survives zeroing", lcr_en_q, 8'h5A);
    cold_rst_n = 1'b0; rst_n = 1'b0; tick(2); cold_rst_n = 1'b1; rst_n = 1'b1;
    tick();
    check("R9 cold clears", lcr_en_q | std_en_q | sp_en_q, 8'h00);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule